// File: doc/BRIEF.md
# Width-Selectable NRZ/CMI Line Serializer

This block takes a parallel data word of 2, 4 or 8 bits and serializes it onto one line output. A static 3-bit mode code picks two things: the parallel width, and whether the line is sent as plain NRZ or CMI-coded. Everything runs on a single fast line clock `clk`. Each data bit always lasts two fast-clock cycles. In CMI mode those two cycles are the two half-bit symbols. In NRZ mode the bit is simply held for both cycles, which amounts to running at half the fast clock.

The slow system word rate is not a separate clock. The block raises a one-cycle `word_tick` enable once per word period, and the parallel word is sampled on that edge into a holding register. At the following word boundary the holding register is moved into the shift register, and bit 0 goes out first.

Two loopback paths are provided. A line-loop select replaces the serialized symbol stream on the line output with an external line-loop input. A separate output carries the serialized NRZ stream for a companion receiver whenever system-loop select is high.

Top module: `ser_line_tx`

## Requirements
- R1: Mode code `mode_sel` = {line code, width[1:0]}. Bit 2 low selects CMI and high selects NRZ. Width field 00 means 2 bits, 01 means 4 bits and 10 means 8 bits. Width field 11 is invalid for either line code.
- R2: With a valid mode, `word_tick` pulses high for exactly one cycle every 2·W fast cycles, where W is the selected width. `par_din` is captured on the rising edge at which `word_tick` is high.
- R3: Parallel bit 0 is the first bit sent, followed by bits 1 up to W-1. Bits at index W and above have no effect on the line.
- R4: In NRZ mode each data bit appears on `line_out` for two consecutive cycles. The first cycle of bit 0 of a word is driven at the 2·W+1-th rising edge after that word's capture edge.
- R5: In CMI mode a data 0 is sent as 0 then 1, using the same timing as R4. A data 1 is sent as two equal half-bits. After reset the first 1 is sent as 00, the next as 11, and the pattern keeps alternating with each further 1.
- R6: For an invalid mode code, `mode_err` is high and `line_out`, `sys_loop_out` and `word_tick` stay low. For a valid code, `mode_err` is low.
- R7: With a valid mode and `lline_sel` high, `line_out` equals `lline_din` delayed by one clock cycle.
- R8: When `sloop_sel` is high, `sys_loop_out` carries the NRZ form of the serialized data with R4 timing, in both line codes. When `sloop_sel` is low, `sys_loop_out` is low.
- R9: While `rst` is high, `line_out`, `sys_loop_out` and `word_tick` are low. After release, the word timing restarts from the start of a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast line clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Static mode code {line code, width} |
| par_din | input | 8 | Parallel data word, bit 0 sent first |
| lline_sel | input | 1 | Line-loop select |
| lline_din | input | 1 | Line-loop data input |
| sloop_sel | input | 1 | System-loop select |
| word_tick | output | 1 | One-cycle word capture enable |
| line_out | output | 1 | Serial line output (NRZ or CMI) |
| sys_loop_out | output | 1 | Serialized NRZ stream for system loopback |
| mode_err | output | 1 | Invalid mode code flag |

## Verification
The hardest case to reach is the CMI level alternation for ones that are separated by zeros, or that cross a word boundary. The level is hidden state that persists across any number of words, and a fault in it shows only as a sign flip many bits later. The stimulus streams several back-to-back words per mode, each aligned to `word_tick`. The word values are chosen so that ones fall at the first and last bit positions and in long runs. Every half-bit is compared against a level tracked in the bench since reset. The same stream also checks the system-loop output against the NRZ expectation.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    localparam int PAR_W = 8;
    localparam int IDX_W = $clog2(PAR_W);

    typedef enum logic {
        CODE_NRZ = 1'b0,
        CODE_CMI = 1'b1
    } line_code_e;

    typedef struct packed {
        logic                 valid;
        line_code_e           code;
        logic [IDX_W-1:0]     last_idx;
    } mode_cfg_t;

    // Width field w selects 2 << w bits; field value 3 is reserved.
    function automatic mode_cfg_t decode_mode(input logic [2:0] m);
        mode_cfg_t c;
        c.valid    = (m[1:0] != 2'b11);
        c.code     = m[2] ? CODE_NRZ : CODE_CMI;
        c.last_idx = c.valid ? IDX_W'((2 << m[1:0]) - 1) : '0;
        return c;
    endfunction

endpackage

// File: rtl/ser_tx_timing.sv
module ser_tx_timing
    import ser_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  mode_cfg_t cfg,
    output logic      half_ph,
    output logic      word_tick
);

    logic [IDX_W-1:0] idx_q;
    logic             ph_q;

    always_ff @(posedge clk) begin
        if (rst || !cfg.valid) begin
            ph_q  <= 1'b0;
            idx_q <= '0;
        end else begin
            ph_q <= ~ph_q;
            if (ph_q) begin
                idx_q <= (idx_q == cfg.last_idx) ? '0 : idx_q + 1'b1;
            end
        end
    end

    assign half_ph   = ph_q;
    assign word_tick = cfg.valid && ph_q && (idx_q == cfg.last_idx);

    AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (rst) // R2
        word_tick |=> !word_tick);

endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter
    import ser_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             half_ph,
    input  logic             word_tick,
    input  logic [PAR_W-1:0] par_din,
    output logic             cur_bit
);

    logic [PAR_W-1:0] hold_q;
    logic [PAR_W-1:0] shreg_q;

    always_ff @(posedge clk) begin
        if (rst || !valid) begin
            hold_q  <= '0;
            shreg_q <= '0;
        end else if (word_tick) begin
            hold_q  <= par_din;
            shreg_q <= hold_q;
        end else if (half_ph) begin
            shreg_q <= shreg_q >> 1;
        end
    end

    assign cur_bit = shreg_q[0];

endmodule

// File: rtl/ser_tx_line_enc.sv
module ser_tx_line_enc
    import ser_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  mode_cfg_t cfg,
    input  logic      half_ph,
    input  logic      cur_bit,
    input  logic      lline_sel,
    input  logic      lline_din,
    input  logic      sloop_sel,
    output logic      line_out,
    output logic      sys_loop_out
);

    logic lvl_q;
    logic sym;
    logic line_q;
    logic sysl_q;

    always_ff @(posedge clk) begin
        if (rst || !cfg.valid) begin
            lvl_q <= 1'b0;
        end else if (cfg.code == CODE_CMI && half_ph && cur_bit) begin
            lvl_q <= ~lvl_q;
        end
    end

    always_comb begin
        if (cfg.code == CODE_CMI) begin
            sym = cur_bit ? lvl_q : half_ph;
        end else begin
            sym = cur_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !cfg.valid) begin
            line_q <= 1'b0;
            sysl_q <= 1'b0;
        end else begin
            line_q <= lline_sel ? lline_din : sym;
            sysl_q <= sloop_sel && cur_bit;
        end
    end

    assign line_out     = line_q;
    assign sys_loop_out = sysl_q;

    AST_NRZ_PAIR: assert property (@(posedge clk) disable iff (rst) // R4
        (cfg.valid && cfg.code == CODE_NRZ && !lline_sel && half_ph &&
         $past(cfg.valid && cfg.code == CODE_NRZ && !lline_sel && !half_ph))
        |=> $stable(line_out));

    AST_CMI_ONE_FLAT: assert property (@(posedge clk) disable iff (rst) // R5
        (cfg.valid && cfg.code == CODE_CMI && !lline_sel && half_ph && cur_bit &&
         $past(cfg.valid && cfg.code == CODE_CMI && !lline_sel && !half_ph))
        |=> $stable(line_out));

endmodule

// File: rtl/ser_line_tx.sv
module ser_line_tx
    import ser_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode_sel,
    input  logic [PAR_W-1:0] par_din,
    input  logic             lline_sel,
    input  logic             lline_din,
    input  logic             sloop_sel,
    output logic             word_tick,
    output logic             line_out,
    output logic             sys_loop_out,
    output logic             mode_err
);

    mode_cfg_t cfg;
    logic      half_ph;
    logic      cur_bit;

    assign cfg      = decode_mode(mode_sel);
    assign mode_err = !cfg.valid;

    ser_tx_timing u_timing (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .half_ph   (half_ph),
        .word_tick (word_tick)
    );

    ser_tx_shifter u_shifter (
        .clk       (clk),
        .rst       (rst),
        .valid     (cfg.valid),
        .half_ph   (half_ph),
        .word_tick (word_tick),
        .par_din   (par_din),
        .cur_bit   (cur_bit)
    );

    ser_tx_line_enc u_enc (
        .clk          (clk),
        .rst          (rst),
        .cfg          (cfg),
        .half_ph      (half_ph),
        .cur_bit      (cur_bit),
        .lline_sel    (lline_sel),
        .lline_din    (lline_din),
        .sloop_sel    (sloop_sel),
        .line_out     (line_out),
        .sys_loop_out (sys_loop_out)
    );

    AST_LINE_LOOP: assert property (@(posedge clk) disable iff (rst) // R7
        (lline_sel && !mode_err) |=> (line_out == $past(lline_din)));

    AST_ERR_LINE_LOW: assert property (@(posedge clk) disable iff (rst) // R6
        mode_err |=> (!line_out && !sys_loop_out));

endmodule

// File: tb/sim_ser_line_tx.sv
module sim_ser_line_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode_sel = 3'b110;
    logic [7:0] par_din = '0;
    logic       lline_sel = 1'b0;
    logic       lline_din = 1'b0;
    logic       sloop_sel = 1'b0;
    logic       word_tick, line_out, sys_loop_out, mode_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] words [6];

    always #10 clk = ~clk;

    ser_line_tx u0 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .par_din(par_din),
        .lline_sel(lline_sel), .lline_din(lline_din), .sloop_sel(sloop_sel),
        .word_tick(word_tick), .line_out(line_out),
        .sys_loop_out(sys_loop_out), .mode_err(mode_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic [2:0] m);
        @(negedge clk);
        rst = 1'b1;
        mode_sel = m;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!word_tick);
    endtask

    // R9: outputs low while reset is held
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        mode_sel = 3'b110;
        lline_sel = 1'b0;
        sloop_sel = 1'b1;
        par_din = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 line_out in reset", line_out, 0);
        check("R9 sys_loop_out in reset", sys_loop_out, 0);
        check("R9 word_tick in reset", word_tick, 0);
        check("R6 mode_err valid code", mode_err, 0);
        rst = 1'b0;
    endtask

    // R2: tick spacing of 2*W cycles, single-cycle pulse
    task automatic t_tick_period(input logic [2:0] m);
        int w, cnt;
        w = 2 << m[1:0];
        do_reset(m);
        wait_tick();
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!word_tick);
        check("R2 word_tick spacing", cnt, 2 * w);
        @(negedge clk);
        check("R2 word_tick single cycle", word_tick, 0);
    endtask

    // R1 R3 R4 R5 R8: stream words and compare each half-bit
    task automatic run_stream(input logic [2:0] m, input logic sl);
        int w;
        bit cmi;
        w = 2 << m[1:0];
        cmi = !m[2];
        sloop_sel = sl;
        lline_sel = 1'b0;
        do_reset(m);
        fork
            begin
                for (int k = 0; k < 7; k++) begin
                    wait_tick();
                    par_din = words[k % 6];
                end
            end
            begin
                logic lvl;
                lvl = 1'b0;
                wait_tick();
                wait_tick();
                @(posedge clk);
                @(posedge clk);
                for (int k = 0; k < 6; k++) begin
                    for (int b = 0; b < w; b++) begin
                        logic d;
                        d = words[k][b];
                        for (int h = 0; h < 2; h++) begin
                            logic exp_l;
                            if (!cmi) exp_l = d;
                            else if (!d) exp_l = (h == 1);
                            else exp_l = lvl;
                            @(negedge clk);
                            if (cmi) check("R5 CMI half-bit on line_out", line_out, exp_l);
                            else check("R4 R3 NRZ bit on line_out", line_out, exp_l);
                            check("R8 sys_loop_out stream", sys_loop_out, sl ? d : 1'b0);
                            check("R1 mode_err for valid code", mode_err, 0);
                            @(posedge clk);
                        end
                        if (cmi && d) lvl = ~lvl;
                    end
                end
            end
        join
    endtask

    // R6: invalid codes give no data
    task automatic t_invalid(input logic [2:0] m);
        int bad_line, bad_tick, bad_sys, bad_err;
        bad_line = 0; bad_tick = 0; bad_sys = 0; bad_err = 0;
        lline_sel = 1'b1;
        sloop_sel = 1'b1;
        par_din = 8'hFF;
        do_reset(m);
        for (int i = 0; i < 40; i++) begin
            lline_din = i[0];
            @(negedge clk);
            if (line_out) bad_line++;
            if (word_tick) bad_tick++;
            if (sys_loop_out) bad_sys++;
            if (!mode_err) bad_err++;
        end
        check("R6 line_out high cycles", bad_line, 0);
        check("R6 word_tick cycles", bad_tick, 0);
        check("R6 sys_loop_out high cycles", bad_sys, 0);
        check("R6 mode_err low cycles", bad_err, 0);
        lline_sel = 1'b0;
        sloop_sel = 1'b0;
    endtask

    // R7: line loop replaces serializer output with one cycle delay
    task automatic t_line_loop(input logic [2:0] m);
        logic prev;
        par_din = 8'hA5;
        lline_sel = 1'b1;
        sloop_sel = 1'b0;
        do_reset(m);
        lline_din = 1'b0;
        prev = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (i > 0) check("R7 line_out follows lline_din", line_out, prev);
            prev = ((i % 3) == 0) ^ ((i % 5) == 1);
            lline_din = prev;
        end
        lline_sel = 1'b0;
    endtask

    initial begin
        t_reset();
        t_tick_period(3'b100);
        t_tick_period(3'b001);
        t_tick_period(3'b110);

        words = '{8'h00, 8'hFF, 8'h81, 8'h5A, 8'h0F, 8'h37};
        run_stream(3'b110, 1'b1);
        run_stream(3'b010, 1'b1);
        words = '{8'hF6, 8'h09, 8'hAB, 8'h54, 8'hC3, 8'h3C};
        run_stream(3'b101, 1'b0);
        run_stream(3'b001, 1'b1);
        words = '{8'hFD, 8'h02, 8'hFF, 8'h01, 8'hFC, 8'hAE};
        run_stream(3'b100, 1'b1);
        run_stream(3'b000, 1'b0);

        t_invalid(3'b011);
        t_invalid(3'b111);
        t_line_loop(3'b101);
        t_line_loop(3'b010);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule